// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block gathers the interrupt sources that belong to each processor core and produces one interrupt request per core. Each core has four timer lines and four mailbox lines of its own. A performance-monitor line and a fast peripheral line are shared between the cores. Per-core enable masks gate the timer lines. A routing mask, changed through separate set and clear registers, decides which cores see the performance-monitor line. The fast peripheral line always goes to core 0.

A core's request is raised whenever its pending word is nonzero. Software reads that word over a small 32-bit register port and services the lowest-numbered set bit first. A zero word means the core has nothing pending. The pending word follows the inputs combinationally and holds no state of its own. The mailbox lines arrive already resolved from mailbox storage elsewhere.

Top module: `local_irq_router`

## Requirements
- R1: After synchronous reset, every timer enable mask and the performance-monitor routing mask are zero. Active timer or monitor lines then raise no request, and every enable register reads 0.
- R2: The timer enable register of core c is at byte address 0x40 + 4*c. Bits 3:0 enable timer sources 0..3 of that core. Written upper bits are dropped and read back as zero. A write to one core's register leaves every other core's register unchanged.
- R3: A write to the monitor set register (0x10) enables routing to core n for each data bit n that is 1. Data bits that are 0 leave routing unchanged.
- R4: A write to the monitor clear register (0x14) disables routing to core n for each data bit n that is 1. Data bits that are 0 leave routing unchanged.
- R5: A read of 0x10 or of 0x14 returns the current routing mask in bits NUM_CORES-1:0. All other bits read as zero.
- R6: The read-only pending word of core c is at 0x60 + 4*c. It has the following fields: bits 3:0 are the core's timer lines ANDed with its enable mask; bits 7:4 are its mailbox lines 0..3; bit 8 is the fast peripheral line; bit 9 is the monitor line ANDed with the core's routing bit. Bits 31:10 are zero.
- R7: irq_o[c] is high exactly when the pending word of core c is nonzero. It follows input changes in the same cycle, with no register in the path.
- R8: A read asserted at one clock edge returns its data, with bus_rvalid high, after the next edge. bus_rvalid is low when no read was asserted. A read of an unmapped address, including the register slot of a core index at or above NUM_CORES, returns zero. A write to a pending word or to an unmapped address changes no state.
- R9: The fast peripheral line appears only in core 0's pending word. Bit 8 is always zero for every other core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| tmr_irq | input | 4*NUM_CORES | Timer lines; bits 4c+3:4c belong to core c |
| mbx_irq | input | 4*NUM_CORES | Mailbox lines; bits 4c+3:4c belong to core c |
| fast_irq | input | 1 | Fast peripheral interrupt line |
| pmu_irq | input | 1 | Performance-monitor interrupt line |
| irq_o | output | NUM_CORES | Interrupt request per core |

## Verification
Requests on irq_o are combinational. The bench changes the interrupt lines on a falling edge and compares irq_o one nanosecond later, within the same low phase. A register write takes effect at the next rising edge, so any read or request check that follows a write starts one cycle after it. Each read produces its data after the rising edge that sampled it. The scoreboard therefore queues the expected word when it issues the read, and pops and compares it at the following falling edge, when bus_rvalid is high.

// File: rtl/lir_pkg.sv
package lir_pkg;

    localparam int TMR_PER_CORE = 4;
    localparam int MBX_PER_CORE = 4;
    localparam int ADDR_W       = 8;
    localparam int DATA_W       = 32;
    localparam int MAX_CORES    = 8;
    localparam int CORE_IDX_W   = $clog2(MAX_CORES);

    localparam logic [ADDR_W-1:0] A_PMON_SET = 8'h10;
    localparam logic [ADDR_W-1:0] A_PMON_CLR = 8'h14;
    localparam logic [2:0]        PG_TMR     = 3'b010;  // 0x40..0x5C
    localparam logic [2:0]        PG_PEND    = 3'b011;  // 0x60..0x7C

    typedef enum logic [2:0] {
        K_NONE,
        K_TMR,
        K_PSET,
        K_PCLR,
        K_PEND
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e             kind;
        logic [CORE_IDX_W-1:0] core;
    } reg_sel_t;

    // Pending word layout, lowest bit first: timers, mailboxes, fast, monitor
    typedef struct packed {
        logic                    pmon;
        logic                    fast;
        logic [MBX_PER_CORE-1:0] mbx;
        logic [TMR_PER_CORE-1:0] tmr;
    } pend_t;

    localparam int PEND_W = $bits(pend_t);

    function automatic reg_sel_t decode(input logic [ADDR_W-1:0] a, input int ncores);
        reg_sel_t s;
        s.kind = K_NONE;
        s.core = a[4:2];
        if (a == A_PMON_SET) begin
            s.kind = K_PSET;
        end else if (a == A_PMON_CLR) begin
            s.kind = K_PCLR;
        end else if (a[1:0] == 2'b00 && int'(a[4:2]) < ncores) begin
            if (a[7:5] == PG_TMR)  s.kind = K_TMR;
            if (a[7:5] == PG_PEND) s.kind = K_PEND;
        end
        return s;
    endfunction

endpackage

// File: rtl/lir_regs.sv
module lir_regs
    import lir_pkg::*;
#(
    parameter int NC = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr,
    input  reg_sel_t                     wsel,
    input  logic [DATA_W-1:0]            wdata,
    output logic [NC-1:0][TMR_PER_CORE-1:0] tmr_en,
    output logic [NC-1:0]                route
);

    for (genvar c = 0; c < NC; c++) begin : g_tmr
        always_ff @(posedge clk) begin
            if (rst)
                tmr_en[c] <= '0;
            else if (wr && wsel.kind == K_TMR && wsel.core == CORE_IDX_W'(c))
                tmr_en[c] <= wdata[TMR_PER_CORE-1:0];
        end

        a_r2_tmr_write: assert property (@(posedge clk) disable iff (rst)
            (wr && wsel.kind == K_TMR && wsel.core == CORE_IDX_W'(c))
            |=> tmr_en[c] == $past(wdata[TMR_PER_CORE-1:0]));

        a_r2_tmr_hold: assert property (@(posedge clk) disable iff (rst)
            !(wr && wsel.kind == K_TMR && wsel.core == CORE_IDX_W'(c))
            |=> $stable(tmr_en[c]));
    end

    always_ff @(posedge clk) begin
        if (rst)
            route <= '0;
        else if (wr && wsel.kind == K_PSET)
            route <= route | wdata[NC-1:0];
        else if (wr && wsel.kind == K_PCLR)
            route <= route & ~wdata[NC-1:0];
    end

    a_r3_set_bits: assert property (@(posedge clk) disable iff (rst)
        (wr && wsel.kind == K_PSET)
        |=> ((route & $past(wdata[NC-1:0])) == $past(wdata[NC-1:0]))
         && ((route & ~$past(wdata[NC-1:0])) == ($past(route) & ~$past(wdata[NC-1:0]))));

    a_r4_clr_bits: assert property (@(posedge clk) disable iff (rst)
        (wr && wsel.kind == K_PCLR)
        |=> ((route & $past(wdata[NC-1:0])) == '0)
         && ((route & ~$past(wdata[NC-1:0])) == ($past(route) & ~$past(wdata[NC-1:0]))));

endmodule

// File: rtl/lir_pend.sv
module lir_pend
    import lir_pkg::*;
#(
    parameter int NC = 4
) (
    input  logic [TMR_PER_CORE*NC-1:0]      tmr_lines,
    input  logic [MBX_PER_CORE*NC-1:0]      mbx_lines,
    input  logic                            fast,
    input  logic                            pmu,
    input  logic [NC-1:0][TMR_PER_CORE-1:0] tmr_en,
    input  logic [NC-1:0]                   route,
    output pend_t [NC-1:0]                  pend
);

    for (genvar c = 0; c < NC; c++) begin : g_core
        always_comb begin
            pend[c].tmr  = tmr_lines[TMR_PER_CORE*c +: TMR_PER_CORE] & tmr_en[c];
            pend[c].mbx  = mbx_lines[MBX_PER_CORE*c +: MBX_PER_CORE];
            pend[c].pmon = pmu & route[c];
        end
        if (c == 0) begin : g_fast
            assign pend[c].fast = fast;
        end else begin : g_nofast
            assign pend[c].fast = 1'b0;
        end
    end

endmodule

// File: rtl/lir_rdport.sv
module lir_rdport
    import lir_pkg::*;
#(
    parameter int NC = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            rd,
    input  reg_sel_t                        rsel,
    input  logic [NC-1:0][TMR_PER_CORE-1:0] tmr_en,
    input  logic [NC-1:0]                   route,
    input  pend_t [NC-1:0]                  pend,
    output logic [DATA_W-1:0]               rdata,
    output logic                            rvalid
);

    logic [DATA_W-1:0] mux;

    always_comb begin
        mux = '0;
        unique case (rsel.kind)
            K_PSET, K_PCLR: mux = DATA_W'(route);
            K_TMR: begin
                for (int c = 0; c < NC; c++)
                    if (rsel.core == CORE_IDX_W'(c)) mux = DATA_W'(tmr_en[c]);
            end
            K_PEND: begin
                for (int c = 0; c < NC; c++)
                    if (rsel.core == CORE_IDX_W'(c)) mux = DATA_W'(pend[c]);
            end
            default: mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd;
            if (rd) rdata <= mux;
        end
    end

    a_r8_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
        rd |=> rvalid);

    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !rd |=> !rvalid);

endmodule

// File: rtl/local_irq_router.sv
module local_irq_router
    import lir_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              bus_wr,
    input  logic                              bus_rd,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [DATA_W-1:0]                 bus_rdata,
    output logic                              bus_rvalid,
    input  logic [TMR_PER_CORE*NUM_CORES-1:0] tmr_irq,
    input  logic [MBX_PER_CORE*NUM_CORES-1:0] mbx_irq,
    input  logic                              fast_irq,
    input  logic                              pmu_irq,
    output logic [NUM_CORES-1:0]              irq_o
);

    reg_sel_t                               sel;
    logic [NUM_CORES-1:0][TMR_PER_CORE-1:0] tmr_en;
    logic [NUM_CORES-1:0]                   route;
    pend_t [NUM_CORES-1:0]                  pend;

    assign sel = decode(bus_addr, NUM_CORES);

    lir_regs #(.NC(NUM_CORES)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr),
        .wsel   (sel),
        .wdata  (bus_wdata),
        .tmr_en (tmr_en),
        .route  (route)
    );

    lir_pend #(.NC(NUM_CORES)) u_pend (
        .tmr_lines (tmr_irq),
        .mbx_lines (mbx_irq),
        .fast      (fast_irq),
        .pmu       (pmu_irq),
        .tmr_en    (tmr_en),
        .route     (route),
        .pend      (pend)
    );

    lir_rdport #(.NC(NUM_CORES)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .rd     (bus_rd),
        .rsel   (sel),
        .tmr_en (tmr_en),
        .route  (route),
        .pend   (pend),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_irq
        assign irq_o[c] = |pend[c];

        a_r7_irq_matches: assert property (@(posedge clk) disable iff (rst)
            irq_o[c] == (pend[c] != '0));

        a_r1_masked_after_reset: assert property (@(posedge clk)
            rst |=> (pend[c].tmr == '0) && !pend[c].pmon);
    end

endmodule

// File: tb/local_irq_router_test.sv
`timescale 1ns/1ps
module local_irq_router_test;

    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [4*NC-1:0] tmr_irq = '0, mbx_irq = '0;
    logic        fast_irq = 1'b0, pmu_irq = 1'b0;
    logic [NC-1:0] irq_o;

    int total = 0, bad = 0;
    bit done = 0;

    logic [3:0]    m_en [NC];
    logic [NC-1:0] m_route;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    local_irq_router #(.NUM_CORES(NC)) uut (.*);

    function automatic logic [31:0] exp_pend(int c);
        logic [31:0] w = '0;
        w[3:0] = tmr_irq[4*c +: 4] & m_en[c];
        w[7:4] = mbx_irq[4*c +: 4];
        w[8]   = (c == 0) ? fast_irq : 1'b0;
        w[9]   = pmu_irq & m_route[c];
        return w;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data when the design returns it
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, bus_rdata, e);
            end
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(string tag);
        logic [NC-1:0] e;
        #1;
        for (int c = 0; c < NC; c++) e[c] = (exp_pend(c) != 0);
        check(tag, 32'(irq_o), 32'(e));
    endtask

    task automatic rd_all_pend(string tag);
        for (int c = 0; c < NC; c++) rd(8'h60 + 8'(4*c), exp_pend(c), tag);
    endtask

    task automatic model_reset();
        for (int c = 0; c < NC; c++) m_en[c] = '0;
        m_route = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        tmr_irq = '1; pmu_irq = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state masks timers and monitor
        chk_irq("R1 irq after reset");
        for (int c = 0; c < NC; c++) rd(8'h40 + 8'(4*c), 32'h0, "R1 timer enable reset");
        rd(8'h10, 32'h0, "R1 route reset");
        rd_all_pend("R1 pending after reset");

        // R2: per-core timer enables, upper bits dropped
        wr(8'h44, 32'hFFFF_FFF5); m_en[1] = 4'h5;
        rd(8'h44, 32'h5, "R2 core1 readback");
        rd(8'h40, 32'h0, "R2 core0 untouched");
        rd(8'h64, 32'h5, "R6 core1 timer pending");
        chk_irq("R7 core1 timer irq");
        wr(8'h4C, 32'hA); m_en[3] = 4'hA;
        @(negedge clk); tmr_irq = 16'h9C3F;
        chk_irq("R7 timer pattern");
        rd_all_pend("R6 timer pattern");
        rd(8'h4C, 32'hA, "R2 core3 readback");

        // R3/R4/R5: monitor routing set/clear
        tmr_irq = '0;
        wr(8'h10, 32'h5); m_route = 4'b0101;
        rd(8'h10, 32'h5, "R5 route via set addr");
        rd(8'h14, 32'h5, "R5 route via clr addr");
        wr(8'h10, 32'h2); m_route = 4'b0111;
        rd(8'h10, 32'h7, "R3 zero bits keep");
        wr(8'h14, 32'h4); m_route = 4'b0011;
        rd(8'h14, 32'h3, "R4 clear bit2");
        wr(8'h14, 32'h0);
        rd(8'h10, 32'h3, "R4 zero clear no effect");
        chk_irq("R7 monitor routing");
        rd_all_pend("R6 monitor pending");
        @(negedge clk); pmu_irq = 1'b0;
        chk_irq("R7 monitor low");

        // R9: fast line reaches core 0 only
        fast_irq = 1'b1;
        chk_irq("R9 fast irq");
        rd_all_pend("R9 fast pending");

        // R6: mailbox lines
        @(negedge clk); fast_irq = 1'b0; mbx_irq = 16'h8421;
        chk_irq("R7 mailbox irq");
        rd_all_pend("R6 mailbox pending");
        @(negedge clk); mbx_irq = 16'h0300;
        chk_irq("R7 only core2 mailbox");
        rd_all_pend("R6 mailbox pending 2");

        // R8: unmapped reads, ignored writes
        rd(8'h30, 32'h0, "R8 unmapped read");
        rd(8'h50, 32'h0, "R8 core index beyond range");
        rd(8'h42, 32'h0, "R8 misaligned read");
        wr(8'h60, 32'hFFFF_FFFF);
        wr(8'h50, 32'hFFFF_FFFF);
        wr(8'h30, 32'hFFFF_FFFF);
        for (int c = 0; c < NC; c++) rd(8'h40 + 8'(4*c), 32'(m_en[c]), "R8 ignored writes keep enables");
        rd(8'h10, 32'(m_route), "R8 ignored writes keep route");
        repeat (2) @(negedge clk);
        check("R8 rvalid idle", 32'(bus_rvalid), 32'h0);

        // R1: reset in mid-run clears everything
        tmr_irq = '1; pmu_irq = 1'b1; mbx_irq = '0;
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0; model_reset();
        chk_irq("R1 irq after second reset");
        rd(8'h48, 32'h0, "R1 enable after second reset");
        rd(8'h14, 32'h0, "R1 route after second reset");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("R8 missing read data", 32'(exp_q.size()), 32'h0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule